// File: doc/BRIEF.md
# PCIe MSI Capture Interrupt Controller

This block sits on the inbound upstream memory-write path of a PCIe root port. It inspects every write and decides whether it is a message-signalled interrupt: the address must equal a programmed 64-bit target and the low half of the data word must match a programmed pattern under a programmed mask. A matching write is consumed, and the data bits that the mask leaves free pick a vector. That vector sets one bit of a 32-bit interrupt status register. Writes that are not MSIs leave the block unchanged, in the same cycle, on a separate memory-traffic strobe.

Software reaches the block through a simple 32-bit register port. Through it, software programs the target address, the enable bit and the match word. It also reads status and mask, and it sets or clears bits of either through dedicated write-one addresses. A single level interrupt output is asserted while any pending bit is unmasked. A parameter gives the status bit that vector 0 lands on. This supports a full 32-vector layout and a narrow layout in which the vectors occupy only the top status bits and the lower bits are left to other software-driven sources.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After synchronous reset every status bit is 0, every mask bit is 1, the enable bit is 0, the target address and match word read 0, and `irq` is low.
- R2: An inbound write is captured as an MSI when all of the following hold: the enable bit (bit 0 of register 0x20) is 1; `in_be` is 4'hF; `in_addr[63:1]` equals the target address bits 63:1; and `(in_data[15:0] & M) == (P & M)`, where M is bits 31:16 and P is bits 15:0 of register 0x28. `in_data[31:16]` takes no part in the decision. The vector is `in_data[15:0] & ~M`, and status bit `VEC_BASE + vector` reads 1 from the cycle after the write.
- R3: While the block is enabled, a write whose address equals the target (bit 0 ignored) never raises `mem_valid`. If it is partial, fails the data match, or carries a vector of `32 - VEC_BASE` or more, it is dropped and no status bit changes.
- R4: Any other write (enable 0, or another address) appears in the same cycle on `mem_valid`, `mem_addr`, `mem_data` and `mem_be` with unchanged address, data and byte enables, and leaves status unchanged.
- R5: Interrupt window: 0x00 reads status; a write to 0x04 sets the status bits written as 1; a write to 0x08 clears the status bits written as 1; 0x0C reads mask; a write to 0x10 sets mask bits; a write to 0x14 clears mask bits. Bits written as 0 keep their value, and any status bit, including those below `VEC_BASE`, can be set and cleared by software.
- R6: Register 0x20 holds target address bits 31:1 in bits 31:1 and the enable in bit 0. Register 0x24 holds target bits 63:32. Register 0x28 holds the match word. All three read back what was written.
- R7: `irq` is high exactly when some bit is set in both status and the inverse of mask.
- R8: If an MSI capture and a software clear of the same status bit fall in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Inbound memory write valid |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| in_be | input | 4 | Inbound byte enables |
| mem_valid | output | 1 | Forwarded ordinary memory write valid |
| mem_addr | output | 64 | Forwarded address |
| mem_data | output | 32 | Forwarded data |
| mem_be | output | 4 | Forwarded byte enables |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench sets up a 32-vector match and then aims writes at the target with bit 0 toggled, with partial byte enables, with mismatching data and with junk in the upper data half. A design that compared all address bits would forward MSIs, and one that matched the data upper half would lose vectors. A design that forwarded failed target hits would leak interrupt writes into memory. Separate directed steps issue a clear and a capture of the same bit together, which a clear-priority bank would lose. They also toggle the enable to show that writes are forwarded while it is off, and they walk mask bits to show `irq` follows only unmasked pending bits.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int REG_AW  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 64;
    localparam int BE_W    = DATA_W / 8;
    localparam int HALF_W  = DATA_W / 2;

    // interrupt window (offsets decoded by software loops)
    localparam logic [REG_AW-1:0] OFS_STAT     = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT_SET = 8'h04;
    localparam logic [REG_AW-1:0] OFS_STAT_CLR = 8'h08;
    localparam logic [REG_AW-1:0] OFS_MASK     = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_MASK_SET = 8'h10;
    localparam logic [REG_AW-1:0] OFS_MASK_CLR = 8'h14;
    // configuration
    localparam logic [REG_AW-1:0] OFS_TGT_LO   = 8'h20;
    localparam logic [REG_AW-1:0] OFS_TGT_HI   = 8'h24;
    localparam logic [REG_AW-1:0] OFS_MATCH    = 8'h28;

    typedef struct packed {
        logic [ADDR_W-1:1] target;
        logic              enable;
        logic [HALF_W-1:0] mask;
        logic [HALF_W-1:0] pattern;
    } msi_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } mwr_t;

    function automatic logic data_hits(input logic [HALF_W-1:0] d,
                                       input logic [HALF_W-1:0] m,
                                       input logic [HALF_W-1:0] p);
        return (d & m) == (p & m);
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output msi_cfg_t          cfg,
    output logic [DATA_W-1:0] tgt_lo_rd,
    output logic [DATA_W-1:0] tgt_hi_rd,
    output logic [DATA_W-1:0] match_rd
);
    logic [DATA_W-1:0] tgt_lo_q, tgt_hi_q, match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_lo_q <= '0;
            tgt_hi_q <= '0;
            match_q  <= '0;
        end else if (wr) begin
            if (addr == OFS_TGT_LO) tgt_lo_q <= wdata;
            if (addr == OFS_TGT_HI) tgt_hi_q <= wdata;
            if (addr == OFS_MATCH)  match_q  <= wdata;
        end
    end

    always_comb begin
        cfg.target  = {tgt_hi_q, tgt_lo_q[DATA_W-1:1]};
        cfg.enable  = tgt_lo_q[0];
        cfg.mask    = match_q[DATA_W-1:HALF_W];
        cfg.pattern = match_q[HALF_W-1:0];
    end

    assign tgt_lo_rd = tgt_lo_q;
    assign tgt_hi_rd = tgt_hi_q;
    assign match_rd  = match_q;

    a_r1_cfg_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tgt_lo_q == '0 && match_q == '0));
endmodule

// File: rtl/msi_match.sv
module msi_match
    import msi_cap_pkg::*;
#(
    parameter int VEC_BASE = 0
) (
    input  msi_cfg_t          cfg,
    input  logic              in_valid,
    input  logic [ADDR_W-1:1] in_addr_hi,
    input  logic [HALF_W-1:0] in_data_lo,
    input  logic [BE_W-1:0]   in_be,
    output logic              forward,
    output logic [DATA_W-1:0] cap_vec
);
    localparam int NUM_VEC = DATA_W - VEC_BASE;

    logic              tgt_hit;
    logic              accept;
    logic [HALF_W-1:0] vec;

    assign tgt_hit = cfg.enable && (in_addr_hi == cfg.target);
    assign accept  = in_valid && tgt_hit && (in_be == '1) &&
                     data_hits(in_data_lo, cfg.mask, cfg.pattern);
    assign vec     = in_data_lo & ~cfg.mask;
    assign forward = in_valid && !tgt_hit;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b < VEC_BASE) begin : g_other
                assign cap_vec[b] = 1'b0;
            end else begin : g_vec
                assign cap_vec[b] = accept && (vec == HALF_W'(b - VEC_BASE));
            end
        end
    endgenerate

    // R2: at most one vector per write
    always_comb a_r2_onehot: assert ($onehot0(cap_vec));
    // R3: a consumed MSI never also goes to memory
    always_comb a_r3_not_both: assert (!(forward && (cap_vec != '0)));
    initial assert (NUM_VEC >= 1);
endmodule

// File: rtl/msi_intr_bank.sv
module msi_intr_bank
    import msi_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cap_vec,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] mask,
    output logic              irq
);
    logic [DATA_W-1:0] st_set, st_clr, mk_set, mk_clr;

    always_comb begin
        st_set = (wr && addr == OFS_STAT_SET) ? wdata : '0;
        st_clr = (wr && addr == OFS_STAT_CLR) ? wdata : '0;
        mk_set = (wr && addr == OFS_MASK_SET) ? wdata : '0;
        mk_clr = (wr && addr == OFS_MASK_CLR) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            // capture is ORed last so it wins over a clear
            status <= ((status | st_set) & ~st_clr) | cap_vec;
            mask   <= (mask | mk_set) & ~mk_clr;
        end
    end

    assign irq = |(status & ~mask);

    a_r1_bank_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == '0 && mask == '1 && !irq));
    a_r8_capture_wins: assert property (@(posedge clk) disable iff (rst)
        (cap_vec != '0) |=> ((status & $past(cap_vec)) == $past(cap_vec)));
    a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_STAT_CLR && cap_vec == '0) |=>
            ((status & $past(wdata)) == '0));
    a_r4_quiet_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr && cap_vec == '0) |=> ($stable(status) && $stable(mask)));
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int VEC_BASE = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic [7:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    input  logic         in_valid,
    input  logic [63:0]  in_addr,
    input  logic [31:0]  in_data,
    input  logic [3:0]   in_be,
    output logic         mem_valid,
    output logic [63:0]  mem_addr,
    output logic [31:0]  mem_data,
    output logic [3:0]   mem_be,
    output logic         irq
);
    msi_cfg_t          cfg;
    logic [DATA_W-1:0] tgt_lo_rd, tgt_hi_rd, match_rd;
    logic [DATA_W-1:0] cap_vec, status, mask;
    logic              forward;

    msi_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cfg(cfg), .tgt_lo_rd(tgt_lo_rd), .tgt_hi_rd(tgt_hi_rd), .match_rd(match_rd)
    );

    msi_match #(.VEC_BASE(VEC_BASE)) u_match (
        .cfg(cfg), .in_valid(in_valid), .in_addr_hi(in_addr[ADDR_W-1:1]),
        .in_data_lo(in_data[HALF_W-1:0]), .in_be(in_be),
        .forward(forward), .cap_vec(cap_vec)
    );

    msi_intr_bank u_bank (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cap_vec(cap_vec), .status(status), .mask(mask), .irq(irq)
    );

    assign mem_valid = forward;
    assign mem_addr  = in_addr;
    assign mem_data  = in_data;
    assign mem_be    = in_be;

    always_comb begin
        unique case (reg_addr)
            OFS_STAT:   reg_rdata = status;
            OFS_MASK:   reg_rdata = mask;
            OFS_TGT_LO: reg_rdata = tgt_lo_rd;
            OFS_TGT_HI: reg_rdata = tgt_hi_rd;
            OFS_MATCH:  reg_rdata = match_rd;
            default:    reg_rdata = '0;
        endcase
    end

    a_r3_target_never_forwarded: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg.enable && in_addr[63:1] == cfg.target) |-> !mem_valid);
    a_r4_disabled_forwards: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg.enable) |-> (mem_valid && cap_vec == '0));
endmodule

// File: tb/test_msi_capture_ctrl.sv
module test_msi_capture_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        in_valid = 0;
    logic [63:0] in_addr = 0;
    logic [31:0] in_data = 0;
    logic [3:0]  in_be = 0;
    logic        mem_valid;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_be;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] TGT   = 64'h0000_000F_FFFF_F000;
    localparam logic [15:0] MMASK = 16'hFFE0;
    localparam logic [15:0] MPAT  = 16'h6540;

    logic [31:0] exp_status = 0;
    logic [31:0] exp_mask   = 32'hFFFF_FFFF;
    logic        enabled    = 0;

    always #2.5 clk = ~clk;

    msi_capture_ctrl i_msi_capture_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_be(mem_be), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic is_tgt(input logic [63:0] a);
        return enabled && (a[63:1] == TGT[63:1]);
    endfunction

    function automatic logic [31:0] cap_of(input logic [63:0] a, input logic [31:0] d,
                                           input logic [3:0] be);
        logic [15:0] v;
        v = d[15:0] & ~MMASK;
        if (is_tgt(a) && be == 4'hF && ((d[15:0] & MMASK) == (MPAT & MMASK)))
            return 32'h1 << v[4:0];
        return 32'h0;
    endfunction

    // drive one inbound write, check forwarding, update model
    task automatic inbound(input string req, input logic [63:0] a, input logic [31:0] d,
                           input logic [3:0] be);
        @(negedge clk);
        in_valid = 1; in_addr = a; in_data = d; in_be = be;
        #1;
        check(req, {63'd0, mem_valid}, {63'd0, !is_tgt(a)});
        if (!is_tgt(a)) begin
            check(req, mem_addr, a);
            check(req, {32'd0, mem_data}, {32'd0, d});
            check(req, {60'd0, mem_be}, {60'd0, be});
        end
        exp_status = exp_status | cap_of(a, d, be);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic check_status(input string req);
        logic [31:0] r;
        reg_read(8'h00, r);
        check(req, {32'd0, r}, {32'd0, exp_status});
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        reg_read(8'h00, r); check("R1 status", {32'd0, r}, 64'h0);
        reg_read(8'h0C, r); check("R1 mask", {32'd0, r}, 64'hFFFF_FFFF);
        reg_read(8'h20, r); check("R1 target lo", {32'd0, r}, 64'h0);
        reg_read(8'h28, r); check("R1 match", {32'd0, r}, 64'h0);
        check("R1 irq", {63'd0, irq}, 64'h0);

        // R4 disabled: target write forwarded, no capture
        reg_write(8'h20, TGT[31:0]);
        reg_write(8'h24, TGT[63:32]);
        reg_write(8'h28, {MMASK, MPAT});
        inbound("R4 disabled", TGT, 32'h0000_6543, 4'hF);
        check_status("R4 disabled no status");

        // R6 readback
        reg_write(8'h20, TGT[31:0] | 32'h1);
        enabled = 1;
        reg_read(8'h20, r); check("R6 lo readback", {32'd0, r}, {32'd0, TGT[31:0] | 32'h1});
        reg_read(8'h24, r); check("R6 hi readback", {32'd0, r}, {32'd0, TGT[63:32]});
        reg_read(8'h28, r); check("R6 match readback", {32'd0, r}, {32'd0, MMASK, MPAT});

        // R2 directed: vectors 0 and 31, addr bit0 set, junk upper half
        inbound("R2 vec0", TGT, 32'h0000_6540, 4'hF);
        inbound("R2 vec31 bit0", TGT | 64'h1, 32'hABCD_655F, 4'hF);
        check_status("R2 vectors");
        // R3 partial and mismatch dropped
        inbound("R3 partial", TGT, 32'h0000_6545, 4'h3);
        inbound("R3 mismatch", TGT, 32'h0000_7545, 4'hF);
        check_status("R3 dropped");

        // R7 irq follows mask
        check("R7 masked irq", {63'd0, irq}, 64'h0);
        reg_write(8'h14, 32'h8000_0000); exp_mask = 32'h7FFF_FFFF;
        reg_read(8'h0C, r); check("R5 mask clr", {32'd0, r}, {32'd0, exp_mask});
        check("R7 irq high", {63'd0, irq}, 64'h1);
        reg_write(8'h10, 32'h8000_0000); exp_mask = 32'hFFFF_FFFF;
        check("R7 irq low again", {63'd0, irq}, 64'h0);

        // R5 set/clear status
        reg_write(8'h04, 32'h0F00_0000); exp_status |= 32'h0F00_0000;
        check_status("R5 set");
        reg_write(8'h08, 32'h8100_0001); exp_status &= ~32'h8100_0001;
        check_status("R5 clear");

        // R8 capture wins over simultaneous clear of bit 5
        reg_write(8'h04, 32'h20); exp_status |= 32'h20;
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'h08; reg_wdata = 32'h20;
        in_valid = 1; in_addr = TGT; in_data = 32'h0000_6545; in_be = 4'hF;
        @(negedge clk);
        reg_wr = 0; in_valid = 0;
        check_status("R8 capture wins");

        // constrained random
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'd7);
        end
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a;
            logic [31:0] d;
            logic [3:0]  be;
            a  = ($urandom % 2) ? (TGT | 64'($urandom % 2)) : {$urandom, $urandom};
            d  = ($urandom % 2) ? {$urandom() >> 16, MPAT | 16'($urandom % 32)} : $urandom;
            be = ($urandom % 5 != 0) ? 4'hF : 4'($urandom);
            inbound("R2 R3 R4 random", a, d, be);
            if ($urandom % 8 == 0) begin
                logic [31:0] c;
                c = $urandom;
                reg_write(8'h08, c);
                exp_status &= ~c;
            end
            check_status("R2 R5 random status");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule